// File: doc/BRIEF.md
# Write Completion Status Reporter

This block builds the byte that a non-volatile memory returns on its 8-bit read bus while its internal programming cycle runs. A host that has just written a byte can poll the memory in two ways and learn when the cycle ends. In the first, it reads back the address it wrote: the top bit comes back inverted until the cycle finishes, and true again afterwards. In the second, it reads any address and watches bit 6, which changes on every read while the memory is busy and stops changing when the cycle is over.

The block receives an accepted-write strobe along with that write's address and data, a reject strobe for writes refused by the protection logic, the busy flag from the programming sequencer, the chip-select and output-enable strobes (both active low), the read address, and the data read from the array. It returns the bus data and the output-enable for the bus tri-state buffers. The write path and the array storage are outside this block.

Top module: `wcs_reporter`

## Requirements
- R1: `bus_oe_o` is 1 in the same cycle exactly when `sel_n_i` and `rden_n_i` are both 0. Otherwise it is 0.
- R2: While `bus_oe_o` is 0, `bus_data_o` is all zeros.
- R3: While `busy_i` is 0 and a read is active, `bus_data_o` equals `array_data_i`.
- R4: While `busy_i` is 1, a write is armed, and `rd_addr_i` equals the last accepted write address, bit 7 of `bus_data_o` is the inverse of bit 7 of the last accepted write data.
- R5: In the situation of R4, bits 5 to 0 of `bus_data_o` equal bits 5 to 0 of the last accepted write data.
- R6: While `busy_i` stays 1, bit 6 of `bus_data_o` in a read differs from bit 6 in the previous read. A read is one unbroken run of cycles with `bus_oe_o` at 1. The toggle state advances in the cycle after a read ends.
- R7: Reads made while `busy_i` is 0 do not advance the toggle state. Suppose bit 6 was b in the last read before busy fell. The first read after busy rises again returns the inverse of b, however many idle reads came between.
- R8: A pulse on `wr_reject_i` disarms the held write. While disarmed and busy, bit 7 at the held address comes from `array_data_i` and is not inverted.
- R9: While `busy_i` is 1 and `rd_addr_i` differs from the held address, bit 7 and bits 5 to 0 come from `array_data_i`.
- R10: When `wr_load_i` and `wr_reject_i` are 1 in the same cycle, the new address and data are captured but the write is left disarmed.
- R11: After reset no write is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal programming cycle in progress |
| wr_load_i | input | 1 | Write accepted: capture address and data, arm |
| wr_reject_i | input | 1 | Write refused by protection: disarm |
| wr_addr_i | input | AW (17) | Address of the written byte |
| wr_data_i | input | DW (8) | Data of the written byte |
| sel_n_i | input | 1 | Chip select, active low |
| rden_n_i | input | 1 | Output enable, active low |
| rd_addr_i | input | AW (17) | Read address |
| array_data_i | input | DW (8) | Data read from the array |
| bus_data_o | output | DW (8) | Data presented to the bus |
| bus_oe_o | output | 1 | Drive enable for the bus buffers |

## Verification
Reads are made in four settings: idle, busy at the held address, busy at another address, and after a rejected write. Comparing them separates the inverted top bit from plain array data, and shows that the low bits come from the held byte only where the address matches. Runs of successive busy reads, with idle reads placed between two busy periods, show whether bit 6 advances per read rather than per clock, and whether it freezes while idle. Held data with the top bit set and with it clear show that the inversion is real, and a cycle with both strobes at once shows which one wins.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Bit positions within the status byte, counted down from the top bit.
    function automatic int poll_pos(input int dw);
        return dw - 1;
    endfunction

    function automatic int tog_pos(input int dw);
        return dw - 2;
    endfunction

    typedef enum logic [1:0] {
        VIEW_ARRAY  = 2'd0,
        VIEW_TOGGLE = 2'd1,
        VIEW_POLL   = 2'd2
    } view_e;

endpackage

// File: rtl/wcs_read_tracker.sv
module wcs_read_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n_i,
    input  logic rden_n_i,
    input  logic busy_i,
    output logic rd_en_o,
    output logic tog_o
);
    typedef struct packed {
        logic rd;
        logic tog;
    } trk_t;

    trk_t st_d, st_q;
    logic rd_now;
    logic rd_end;

    assign rd_now = !sel_n_i && !rden_n_i;

    always_comb begin
        st_d    = st_q;
        rd_end  = st_q.rd && !rd_now;
        st_d.rd = rd_now;
        if (rd_end && busy_i) begin
            st_d.tog = !st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en_o = rd_now;
    assign tog_o   = st_q.tog;
endmodule

// File: rtl/wcs_write_hold.sv
module wcs_write_hold #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          reject_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    output logic          armed_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        logic          armed;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr  = addr_i;
            st_d.data  = data_i;
            st_d.armed = 1'b1;
        end
        if (reject_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = st_q.armed;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
    import wcs_pkg::*;
#(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          rd_en_i,
    input  logic          busy_i,
    input  logic          armed_i,
    input  logic          tog_i,
    input  logic [AW-1:0] held_addr_i,
    input  logic [DW-1:0] held_data_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] array_data_i,
    output logic [DW-1:0] data_o
);
    localparam int PB = poll_pos(DW);
    localparam int TB = tog_pos(DW);

    view_e view;

    always_comb begin
        if (!busy_i) begin
            view = VIEW_ARRAY;
        end else if (armed_i && rd_addr_i == held_addr_i) begin
            view = VIEW_POLL;
        end else begin
            view = VIEW_TOGGLE;
        end
    end

    always_comb begin
        data_o = '0;
        if (rd_en_i) begin
            case (view)
                VIEW_POLL: begin
                    data_o     = held_data_i;
                    data_o[PB] = !held_data_i[PB];
                    data_o[TB] = tog_i;
                end
                VIEW_TOGGLE: begin
                    data_o     = array_data_i;
                    data_o[TB] = tog_i;
                end
                default: data_o = array_data_i;
            endcase
        end
    end
endmodule

// File: rtl/wcs_reporter.sv
module wcs_reporter #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          wr_load_i,
    input  logic          wr_reject_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          sel_n_i,
    input  logic          rden_n_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [DW-1:0] array_data_i,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_oe_o
);
    logic          rd_en;
    logic          tog;
    logic          armed;
    logic [AW-1:0] held_addr;
    logic [DW-1:0] held_data;

    wcs_read_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_n_i  (sel_n_i),
        .rden_n_i (rden_n_i),
        .busy_i   (busy_i),
        .rd_en_o  (rd_en),
        .tog_o    (tog)
    );

    wcs_write_hold #(.AW(AW), .DW(DW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wr_load_i),
        .reject_i (wr_reject_i),
        .addr_i   (wr_addr_i),
        .data_i   (wr_data_i),
        .armed_o  (armed),
        .addr_o   (held_addr),
        .data_o   (held_data)
    );

    wcs_status_mux #(.AW(AW), .DW(DW)) u_mux (
        .rd_en_i      (rd_en),
        .busy_i       (busy_i),
        .armed_i      (armed),
        .tog_i        (tog),
        .held_addr_i  (held_addr),
        .held_data_i  (held_data),
        .rd_addr_i    (rd_addr_i),
        .array_data_i (array_data_i),
        .data_o       (bus_data_o)
    );

    assign bus_oe_o = rd_en;
endmodule

// File: rtl/wcs_reporter_chk.sv
module wcs_reporter_chk #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_i,
    input logic          sel_n_i,
    input logic          rden_n_i,
    input logic [DW-1:0] array_data_i,
    input logic [DW-1:0] bus_data_o,
    input logic          bus_oe_o
);
    logic oe_prev_q;
    logic seen_b6_q;
    logic seen_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_prev_q <= 1'b0;
            seen_b6_q <= 1'b0;
            seen_ok_q <= 1'b0;
        end else begin
            oe_prev_q <= bus_oe_o;
            if (!busy_i) begin
                seen_ok_q <= 1'b0;
            end else if (bus_oe_o) begin
                seen_b6_q <= bus_data_o[DW-2];
                seen_ok_q <= 1'b1;
            end
        end
    end

    assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n_i || rden_n_i) |-> !bus_oe_o);

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_data_o == '0));

    assert_idle_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && bus_oe_o) |-> (bus_data_o == array_data_i));

    assert_toggle_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && seen_ok_q && bus_oe_o && !oe_prev_q) |-> (bus_data_o[DW-2] != seen_b6_q));
endmodule

bind wcs_reporter wcs_reporter_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .sel_n_i      (sel_n_i),
    .rden_n_i     (rden_n_i),
    .array_data_i (array_data_i),
    .bus_data_o   (bus_data_o),
    .bus_oe_o     (bus_oe_o)
);

// File: tb/wcs_reporter_test.sv
module wcs_reporter_test;
    localparam int AW = 17;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy_i = 1'b0;
    logic          wr_load_i = 1'b0;
    logic          wr_reject_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          sel_n_i = 1'b1;
    logic          rden_n_i = 1'b1;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] array_data_i;
    logic [DW-1:0] bus_data_o;
    logic          bus_oe_o;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] rv;

    always #10 clk = !clk;

    // Array model: content derived from address.
    assign array_data_i = rd_addr_i[7:0] ^ 8'h5A;

    wcs_reporter #(.AW(AW), .DW(DW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .wr_load_i    (wr_load_i),
        .wr_reject_i  (wr_reject_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .sel_n_i      (sel_n_i),
        .rden_n_i     (rden_n_i),
        .rd_addr_i    (rd_addr_i),
        .array_data_i (array_data_i),
        .bus_data_o   (bus_data_o),
        .bus_oe_o     (bus_oe_o)
    );

    function automatic logic [7:0] arr(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d, input logic rej);
        @(negedge clk);
        wr_addr_i   = a;
        wr_data_i   = d;
        wr_load_i   = 1'b1;
        wr_reject_i = rej;
        @(negedge clk);
        wr_load_i   = 1'b0;
        wr_reject_i = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr_i = a;
        sel_n_i   = 1'b0;
        rden_n_i  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #2 d = bus_data_o;
        @(negedge clk);
        sel_n_i  = 1'b1;
        rden_n_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        #2;
        check("R1 reset oe", bus_oe_o, 0);
        check("R2 reset data", bus_data_o, 0);
    endtask

    task automatic t_strobes;
        @(negedge clk);
        rd_addr_i = 17'h00033;
        sel_n_i = 1'b1; rden_n_i = 1'b0;
        #2 check("R1 sel high oe", bus_oe_o, 0);
        check("R2 sel high data", bus_data_o, 0);
        @(negedge clk);
        sel_n_i = 1'b0; rden_n_i = 1'b1;
        #2 check("R1 rden high oe", bus_oe_o, 0);
        @(negedge clk);
        rden_n_i = 1'b0;
        #2 check("R1 both low oe", bus_oe_o, 1);
        @(negedge clk);
        sel_n_i = 1'b1; rden_n_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_idle;
        do_read(17'h00010, rv);
        check("R3 idle read", rv, arr(17'h00010));
        do_read(17'h1ABCD, rv);
        check("R3 idle read 2", rv, arr(17'h1ABCD));
    endtask

    task automatic t_poll;
        logic [7:0] a, b;
        do_write(17'h15555, 8'h3C, 1'b0);
        busy_i = 1'b1;
        do_read(17'h15555, a);
        check("R4 poll bit inverted", a[7], 1);
        check("R5 low bits held", a[5:0], 6'h3C);
        do_read(17'h15555, b);
        check("R6 toggle read 2", b[6], !a[6]);
        check("R4 poll bit stays", b[7], 1);
        do_read(17'h02AAA, rv);
        check("R6 toggle read 3", rv[6], a[6]);
        check("R9 other addr top", rv[7], arr(17'h02AAA) >> 7);
        check("R9 other addr low", rv[5:0], arr(17'h02AAA) & 8'h3F);
        busy_i = 1'b0;
    endtask

    task automatic t_freeze;
        logic [7:0] a;
        busy_i = 1'b1;
        do_read(17'h00001, a);
        busy_i = 1'b0;
        do_read(17'h00001, rv);
        check("R7 idle true data", rv, arr(17'h00001));
        do_read(17'h00001, rv);
        do_read(17'h00001, rv);
        busy_i = 1'b1;
        do_read(17'h00001, rv);
        check("R7 toggle frozen while idle", rv[6], !a[6]);
        busy_i = 1'b0;
    endtask

    task automatic t_top_set;
        do_write(17'h00400, 8'hA5, 1'b0);
        busy_i = 1'b1;
        do_read(17'h00400, rv);
        check("R4 top set reads zero", rv[7], 0);
        check("R5 low bits A5", rv[5:0], 6'h25);
        busy_i = 1'b0;
        do_read(17'h00400, rv);
        check("R3 done true data", rv, arr(17'h00400));
    endtask

    task automatic t_reject;
        do_write(17'h00123, 8'h11, 1'b0);
        @(negedge clk);
        wr_reject_i = 1'b1;
        @(negedge clk);
        wr_reject_i = 1'b0;
        busy_i = 1'b1;
        do_read(17'h00123, rv);
        check("R8 rejected top bit", rv[7], arr(17'h00123) >> 7);
        check("R8 rejected low bits", rv[5:0], arr(17'h00123) & 8'h3F);
        busy_i = 1'b0;
        do_write(17'h00200, 8'h00, 1'b1);
        busy_i = 1'b1;
        do_read(17'h00200, rv);
        check("R10 both strobes disarmed", rv[7], arr(17'h00200) >> 7);
        check("R10 low bits array", rv[5:0], arr(17'h00200) & 8'h3F);
        busy_i = 1'b0;
    endtask

    task automatic t_reset_unarmed;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        busy_i = 1'b1;
        do_read(17'h00000, rv);
        check("R11 unarmed after reset", rv[7], arr(17'h00000) >> 7);
        busy_i = 1'b0;
    endtask

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_strobes();
        t_idle();
        t_poll();
        t_freeze();
        t_top_set();
        t_reject();
        t_reset_unarmed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule